// File: doc/BRIEF.md
# Page Translation Buffer with Cache Address Split

This block translates virtual addresses to physical addresses through a small, fully associative table of recent page mappings. A lookup presents a 32-bit virtual address: the upper 20 bits are the virtual page and the lower 12 bits are the page offset. Every valid entry compares its page tag against the request in the same cycle. On a hit, the block returns the physical address, which is the stored 20-bit physical page followed by the unchanged offset. It also returns that address already split into the tag, index and byte-offset fields of a 16K-line direct-mapped cache.

Each entry holds a valid bit, a reference bit, a dirty bit and two access-rights bits. Access rights are checked on every hit. A load or store that the rights forbid reports a protection fault and produces no address. When no entry matches, the block raises a miss. Whatever resolves the miss then delivers the new mapping over a valid/ready fill stream.

The fill stream has no back-pressure during normal operation. `fill_ready` is low during reset and from the first clock edge after reset it stays high. A transfer happens on any clock edge where `fill_valid` and `fill_ready` are both high. The entry being replaced is chosen from the valid and reference bits.

Top module: `va_xlate_tlb`

## Requirements
- R1: While reset is active, `fill_ready` is low. After reset no entry is valid, so every lookup misses. `fill_ready` goes high at the first clock edge after reset is released.
- R2: When `lk_valid` is high and a valid entry's tag equals `lk_vaddr[31:12]`, the result appears in the same cycle. If the access is allowed, `hit` is high and `pa` equals {stored physical page, `lk_vaddr[11:0]`}.
- R3: On a hit, `cache_tag` = `pa[31:16]`, `cache_idx` = `pa[15:2]` and `byte_off` = `pa[1:0]`.
- R4: A lookup that matches no valid entry raises `miss`. When there is no hit, `pa` and the cache fields are zero. When `lk_valid` is low, none of `hit`, `miss` and `prot_fault` is high.
- R5: A fill handshake writes the entry at that clock edge. A lookup of the filled page in the next cycle matches it. Once high after reset, `fill_ready` stays high.
- R6: While any entry is invalid, a fill goes to the invalid entry with the lowest index.
- R7: While all entries are valid, a fill replaces the lowest-indexed entry whose reference bit is clear. A freshly filled entry starts with its reference bit set.
- R8: If all entries are valid and all reference bits are set, a fill first clears every reference bit and then replaces entry 0.
- R9: A hit sets the reference bit of the entry that hit, which protects it from the next replacement.
- R10: Access rights are encoded as 00 = no access, 01 = read only, 10 = read/write, 11 = read/execute. A matching lookup raises `prot_fault` instead of `hit` in two cases: the rights are 00, or `lk_write` is high and the rights are not 10.
- R11: `hit_dirty` reports the dirty bit of the entry that hit, as it stood before this access. A store that hits sets that dirty bit. A faulting store leaves it unchanged. A fill loads the dirty bit from `fill_dirty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a store |
| hit | output | 1 | Allowed access found a mapping |
| miss | output | 1 | No valid mapping for the page |
| prot_fault | output | 1 | Mapping found but access denied |
| pa | output | 32 | Physical address on a hit, else zero |
| cache_tag | output | 16 | Cache tag field of `pa` |
| cache_idx | output | 14 | Cache line index field of `pa` |
| byte_off | output | 2 | Byte within word field of `pa` |
| hit_dirty | output | 1 | Dirty bit of the hit entry before this access |
| fill_valid | input | 1 | Fill entry offered |
| fill_ready | output | 1 | Fill entry can be accepted |
| fill_vpn | input | 20 | Virtual page of the fill |
| fill_ppn | input | 20 | Physical page of the fill |
| fill_rights | input | 2 | Access rights of the fill |
| fill_dirty | input | 1 | Initial dirty bit of the fill |

## Verification
The assertions check on every cycle that hit, miss and fault are mutually exclusive and only occur with a request, and that a hit preserves the page offset. They also check that no address leaks out without a hit, that a just-filled page is found on the next cycle, and that the fill stream never withdraws readiness. Victim choice under the three replacement orderings, reference-bit aging, rights enforcement and the dirty history can only be shown by the bench's scenarios. The bench fills the table, forces evictions and observes which pages then miss, comparing every cycle against a model of the whole table.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  typedef enum logic [1:0] {
    AR_NONE = 2'b00,
    AR_RO   = 2'b01,
    AR_RW   = 2'b10,
    AR_RX   = 2'b11
  } acc_rights_e;
endpackage

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
module tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 6
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]              key,
  output logic                          found,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign found = |match;
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] refb,
  output logic [IDX_W-1:0]   idx,
  output logic               all_ref
);
  logic [IDX_W-1:0] inv_idx;
  logic [IDX_W-1:0] clr_idx;
  logic             have_inv;
  logic             have_clr;

  // downward scans so the lowest index is the last one written
  always_comb begin
    inv_idx  = '0;
    clr_idx  = '0;
    have_inv = 1'b0;
    have_clr = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        inv_idx  = IDX_W'(i);
        have_inv = 1'b1;
      end
      if (!refb[i]) begin
        clr_idx  = IDX_W'(i);
        have_clr = 1'b1;
      end
    end
  end

  assign all_ref = !have_inv && !have_clr;
  assign idx     = have_inv ? inv_idx : (have_clr ? clr_idx : '0);
endmodule

// File: rtl/tlb_pa_split.sv
`timescale 1ns/1ps
module tlb_pa_split #(
  parameter int PA_W   = 32,
  parameter int CIDX_W = 14,
  parameter int BOFF_W = 2,
  localparam int CTAG_W = PA_W - CIDX_W - BOFF_W
) (
  input  logic [PA_W-1:0]   pa,
  output logic [CTAG_W-1:0] ctag,
  output logic [CIDX_W-1:0] cidx,
  output logic [BOFF_W-1:0] boff
);
  assign boff = pa[BOFF_W-1:0];
  assign cidx = pa[BOFF_W+CIDX_W-1:BOFF_W];
  assign ctag = pa[PA_W-1:BOFF_W+CIDX_W];
endmodule

// File: rtl/va_xlate_tlb.sv
`timescale 1ns/1ps
module va_xlate_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int CIDX_W  = 14,
  parameter int BOFF_W  = 2,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int CTAG_W = PA_W - CIDX_W - BOFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  output logic              hit,
  output logic              miss,
  output logic              prot_fault,
  output logic [PA_W-1:0]   pa,
  output logic [CTAG_W-1:0] cache_tag,
  output logic [CIDX_W-1:0] cache_idx,
  output logic [BOFF_W-1:0] byte_off,
  output logic              hit_dirty,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [1:0]        fill_rights,
  input  logic              fill_dirty
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            v_q, r_q, d_q;
  logic [ENTRIES-1:0]            r_nx, d_nx;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][1:0]       ar_q;
  logic                          rdy_q;

  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  logic             found;
  logic [IDX_W-1:0] hidx;
  logic [IDX_W-1:0] vic;
  logic             all_ref;
  logic             deny;
  logic             fill_fire;
  acc_rights_e      hrights;

  assign lk_vpn    = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off    = lk_vaddr[OFF_W-1:0];
  assign fill_ready = rdy_q;
  assign fill_fire = fill_valid && rdy_q;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_cam (
    .valid (v_q),
    .tags  (tag_q),
    .key   (lk_vpn),
    .found (found),
    .idx   (hidx)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vic (
    .valid   (v_q),
    .refb    (r_q),
    .idx     (vic),
    .all_ref (all_ref)
  );

  assign hrights = acc_rights_e'(ar_q[hidx]);
  assign deny    = (hrights == AR_NONE) || (lk_write && (hrights != AR_RW));

  assign hit        = lk_valid && found && !deny;
  assign prot_fault = lk_valid && found && deny;
  assign miss       = lk_valid && !found;
  assign pa         = hit ? {ppn_q[hidx], lk_off} : '0;
  assign hit_dirty  = hit && d_q[hidx];

  tlb_pa_split #(.PA_W(PA_W), .CIDX_W(CIDX_W), .BOFF_W(BOFF_W)) u_split (
    .pa   (pa),
    .ctag (cache_tag),
    .cidx (cache_idx),
    .boff (byte_off)
  );

  // aging first, then the hit mark, then the fill overrides its slot
  always_comb begin
    r_nx = r_q;
    d_nx = d_q;
    if (fill_fire && all_ref) r_nx = '0;
    if (hit) r_nx[hidx] = 1'b1;
    if (hit && lk_write) d_nx[hidx] = 1'b1;
    if (fill_fire) begin
      r_nx[vic] = 1'b1;
      d_nx[vic] = fill_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= '0;
      r_q   <= '0;
      d_q   <= '0;
      tag_q <= '0;
      ppn_q <= '0;
      ar_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      r_q   <= r_nx;
      d_q   <= d_nx;
      if (fill_fire) begin
        v_q[vic]   <= 1'b1;
        tag_q[vic] <= fill_vpn;
        ppn_q[vic] <= fill_ppn;
        ar_q[vic]  <= fill_rights;
      end
    end
  end
endmodule

// File: rtl/va_xlate_tlb_chk.sv
`timescale 1ns/1ps
module va_xlate_tlb_chk #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int CTAG_W = 16,
  parameter int CIDX_W = 14,
  parameter int BOFF_W = 2,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic              lk_write,
  input logic              hit,
  input logic              miss,
  input logic              prot_fault,
  input logic [PA_W-1:0]   pa,
  input logic [CTAG_W-1:0] cache_tag,
  input logic [CIDX_W-1:0] cache_idx,
  input logic [BOFF_W-1:0] byte_off,
  input logic              hit_dirty,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic [1:0]        fill_rights
);
  logic fill_fire;
  assign fill_fire = fill_valid && fill_ready;

  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, prot_fault}));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(hit || miss || prot_fault));

  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pa[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  p_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (pa == '0 && cache_tag == '0 && cache_idx == '0 && byte_off == '0));

  p_fill_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire ##1 (lk_valid && !lk_write && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)
                    && $past(fill_rights) != 2'b00)) |-> hit);

  p_dirty_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dirty |-> hit);

  p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_ready) |-> fill_ready);
endmodule

bind va_xlate_tlb va_xlate_tlb_chk #(
  .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
  .CTAG_W(CTAG_W), .CIDX_W(CIDX_W), .BOFF_W(BOFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_write(lk_write), .hit(hit), .miss(miss), .prot_fault(prot_fault),
  .pa(pa), .cache_tag(cache_tag), .cache_idx(cache_idx), .byte_off(byte_off),
  .hit_dirty(hit_dirty), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .fill_vpn(fill_vpn), .fill_rights(fill_rights)
);

// File: tb/va_xlate_tlb_test.sv
`timescale 1ns/1ps
module va_xlate_tlb_test;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        hit, miss, prot_fault, hit_dirty, fill_ready;
  logic [31:0] pa;
  logic [15:0] cache_tag;
  logic [13:0] cache_idx;
  logic [1:0]  byte_off;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  fill_rights = '0;
  logic        fill_dirty = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  bit          m_v [N];
  bit          m_r [N];
  bit          m_d [N];
  logic [19:0] m_tag [N];
  logic [19:0] m_ppn [N];
  logic [1:0]  m_ar [N];

  always #2 clk = ~clk;

  va_xlate_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .hit(hit), .miss(miss), .prot_fault(prot_fault),
    .pa(pa), .cache_tag(cache_tag), .cache_idx(cache_idx), .byte_off(byte_off),
    .hit_dirty(hit_dirty), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rights(fill_rights),
    .fill_dirty(fill_dirty)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int find(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int pick();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (!m_r[i]) return i;
    return -1;
  endfunction

  function automatic bit denied(input logic [1:0] ar, input bit wr);
    return (ar == 2'b00) || (wr && ar != 2'b10);
  endfunction

  // one cycle: drive after falling edge, check before rising edge, update model
  task automatic cyc(input bit lv, input logic [31:0] va, input bit wr,
                     input bit fv, input logic [19:0] fvpn, input logic [19:0] fppn,
                     input logic [1:0] frt, input bit fd, input string req);
    int idx, vic;
    bit e_hit, e_miss, e_flt, e_dirty, fire, allr;
    logic [31:0] e_pa;
    lk_valid = lv; lk_vaddr = va; lk_write = wr;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_rights = frt; fill_dirty = fd;
    #1;
    idx = find(va[31:12]);
    e_miss = lv && idx < 0;
    e_flt  = lv && idx >= 0 && denied(m_ar[idx], wr);
    e_hit  = lv && idx >= 0 && !e_flt;
    e_pa   = e_hit ? {m_ppn[idx], va[11:0]} : 32'h0;
    e_dirty = e_hit && m_d[idx];
    chk({hit, miss, prot_fault, hit_dirty} == {e_hit, e_miss, e_flt, e_dirty} && pa == e_pa, req,
        {28'h0, hit, miss, prot_fault, hit_dirty, pa}, {28'h0, e_hit, e_miss, e_flt, e_dirty, e_pa});
    chk({cache_tag, cache_idx, byte_off} == {e_pa[31:16], e_pa[15:2], e_pa[1:0]}, "R3",
        {32'h0, cache_tag, cache_idx, byte_off}, {32'h0, e_pa});
    fire = fv && fill_ready;
    vic  = pick();
    allr = (vic < 0);
    @(posedge clk);
    if (fire && allr) for (int i = 0; i < N; i++) m_r[i] = 1'b0;
    if (e_hit) m_r[idx] = 1'b1;
    if (e_hit && wr) m_d[idx] = 1'b1;
    if (fire) begin
      if (vic < 0) vic = 0;
      m_v[vic] = 1'b1; m_r[vic] = 1'b1; m_d[vic] = fd;
      m_tag[vic] = fvpn; m_ppn[vic] = fppn; m_ar[vic] = frt;
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [19:0] vpn, input bit wr, input string req);
    cyc(1'b1, {vpn, 12'($urandom)}, wr, 1'b0, '0, '0, '0, 1'b0, req);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [1:0] rt, input string req);
    cyc(1'b0, '0, 1'b0, 1'b1, vpn, 20'($urandom), rt, 1'b0, req);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1f3a);
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_r[i] = 0; m_d[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_ar[i] = '0;
    end
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fill_ready == 1'b0, "R1", {63'h0, fill_ready}, 64'h0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(fill_ready == 1'b1, "R1", {63'h0, fill_ready}, 64'h1);
    look(20'h00100, 1'b0, "R1");

    // R6: fill the empty table in index order, rights cycling 00..11
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 2'(i % 4), "R6");
    // R2 R10 R11: lookups across the rights encodings
    for (int i = 0; i < N; i++) look(20'h00100 + 20'(i), 1'b0, "R2");
    look(20'h00102, 1'b1, "R11");
    look(20'h00102, 1'b0, "R11");
    look(20'h00101, 1'b1, "R10");
    look(20'h00101, 1'b0, "R10");
    look(20'h00103, 1'b1, "R10");
    look(20'h00104, 1'b0, "R10");
    look(20'h00300, 1'b0, "R4");
    cyc(1'b0, 32'h00105abc, 1'b0, 1'b0, '0, '0, '0, 1'b0, "R4");

    // R8: all referenced, fill clears and replaces entry 0
    fill(20'h00200, 2'b10, "R8");
    look(20'h00100, 1'b0, "R8");
    look(20'h00200, 1'b0, "R5");
    // R9 R7: hits on entries 1 and 2 protect them, entry 3 goes
    look(20'h00101, 1'b0, "R9");
    look(20'h00102, 1'b0, "R9");
    fill(20'h00201, 2'b01, "R7");
    look(20'h00103, 1'b0, "R7");
    look(20'h00201, 1'b0, "R7");
    look(20'h00101, 1'b0, "R9");
    look(20'h00104, 1'b0, "R7");
    fill(20'h00202, 2'b11, "R7");
    look(20'h00105, 1'b0, "R7");

    // constrained random mix of lookups and fills
    for (int k = 0; k < 4000; k++) begin
      logic [19:0] lv, fvp;
      bit fv;
      lv  = 20'h00100 + 20'($urandom % 96);
      fvp = 20'h00100 + 20'($urandom % 96);
      fv  = ($urandom % 4 == 0) && (find(fvp) < 0);
      cyc(($urandom % 10) != 0, {lv, 12'($urandom)}, ($urandom % 5) < 2,
          fv, fvp, 20'($urandom), 2'($urandom), 1'($urandom), "R2");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule